// File: doc/BRIEF.md
# Error and Legacy Interrupt Status Controller

This block gathers six error event strobes from a PCIe controller and four legacy level-sensitive interrupt inputs (INTA..INTD) into software-visible status. Each error event sets a sticky status bit that software clears by writing a one to it. An enable mask selects which set bits drive the error interrupt output. The enable mask is changed through a pair of registers: one sets enable bits and the other clears them. A fixed pair of error bits forms a fatal class, which has its own output.

Each legacy line has a status bit that tracks its input level, and an enable bit with its own set and clear registers. It also has an internal arm flag. The host line for a legacy input pulses for one cycle when the line is pending, enabled and armed, and the arm flag then drops. Software re-arms the line by writing the line number to a shared end-of-interrupt register. If the input is still high and enabled at that point, the line pulses again.

Access is through a simple word-addressed write strobe with combinational read data. Addresses are byte offsets. The legacy register groups repeat every 16 bytes, and the `N_INTX` parameter must stay at 4 or below so that the groups do not reach the error status word.

Top module: `eic_top`

## Requirements
- R1: After synchronous active-low reset, all status and enable bits read 0, `err_irq`, `err_fatal` and `intx_irq` are 0, and every legacy line is armed.
- R2: Error status at offset 0x1C4 uses bits [5:0]: 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 AXI tag lookup fatal, 5 ECRC. A high `err_event[k]` at a clock edge sets bit k, and the bit stays set until a write to 0x1C4 with bit k = 1. Writing 0 to a bit leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R3: Writing to 0x1C8 ORs data bits [5:0] into the error enable mask. Writing to 0x1CC clears the mask bits where the data is 1. Reading either offset returns the mask in bits [5:0]. Zero data changes nothing.
- R4: `err_irq` is the OR of status AND enable over bits [5:0]. `err_fatal` is the same OR restricted to bits 1 and 4. Both follow the registers with no further delay.
- R5: Legacy status for line i reads at 0x184+16*i in bit 0. It equals the line's input level sampled at the previous clock edge. Writes to that offset have no effect.
- R6: Writing bit 0 = 1 to 0x188+16*i sets the enable of line i. Writing bit 0 = 1 to 0x18C+16*i clears it. Both offsets read the enable in bit 0. A disabled line never pulses.
- R7: `intx_irq[i]` is high for exactly one cycle when line i's status and enable are both 1 while the line is armed. The line is then disarmed and stays low while the input remains high.
- R8: Writing the value i (the full 32-bit data equal to i, with i < N_INTX) to 0x050 re-arms line i only, in the cycle after the write edge. The line pulses again at once if its status and enable are still 1. Any other data value re-arms nothing.
- R9: Offsets not listed above read 0, and writes to them change no state. The offset 0x1C4 is never decoded as a legacy group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| err_event | input | 6 | Error event strobes, one per status bit |
| intx_level | input | N_INTX | Legacy interrupt input levels |
| err_irq | output | 1 | Any enabled error status bit set |
| err_fatal | output | 1 | Any enabled fatal-class error bit set |
| intx_irq | output | N_INTX | Per-line legacy host interrupt pulse |

## Verification
A status bit that drops without a clear, or that misses an event, shows on the next read of 0x1C4. It also shows at once on `err_irq` whenever that bit is enabled. A wrong fatal mask makes `err_fatal` disagree with the enabled status in the cycle after the event. A stuck or lost arm flag shows as a repeated pulse, or as a missing pulse, in the cycle right after the end-of-interrupt write. A decode error shows as an enable or status change at an offset that should have had no effect.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
// Shared constants for the error / legacy interrupt status controller.
// Assumes byte offsets and 32-bit word registers.
package eic_pkg;
    localparam int ERR_W          = 6;
    localparam int DATA_W         = 32;
    localparam int ERR_STAT_OFS   = 'h1C4;
    localparam int ERR_SET_OFS    = 'h1C8;
    localparam int ERR_CLR_OFS    = 'h1CC;
    localparam int INTX_STAT_OFS  = 'h184;
    localparam int INTX_SET_OFS   = 'h188;
    localparam int INTX_CLR_OFS   = 'h18C;
    localparam int INTX_STRIDE    = 16;
    localparam int EOI_OFS        = 'h050;

    // Error status bit positions (software decodes these).
    typedef enum int {
        EB_SYSTEM   = 0,
        EB_FATAL    = 1,
        EB_NONFATAL = 2,
        EB_CORR     = 3,
        EB_TAGFATAL = 4,
        EB_ECRC     = 5
    } err_bit_e;

    localparam logic [ERR_W-1:0] FATAL_MASK =
        ERR_W'((1 << EB_FATAL) | (1 << EB_TAGFATAL));
endpackage

// File: rtl/eic_decode.sv
`timescale 1ns/1ps
// Address decoder and read multiplexer.
// Turns a write strobe plus byte offset into one-hot register strobes,
// decodes the end-of-interrupt data into a per-line re-arm vector, and
// returns read data combinationally. Assumes N_INTX <= 4 so that the legacy
// groups end below the error status offset.
module eic_decode #(
    parameter int AW     = 12,
    parameter int N_INTX = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [AW-1:0]                reg_addr,
    input  logic [eic_pkg::DATA_W-1:0]   reg_wdata,
    input  logic [eic_pkg::ERR_W-1:0]    err_stat,
    input  logic [eic_pkg::ERR_W-1:0]    err_en,
    input  logic [N_INTX-1:0]            intx_stat,
    input  logic [N_INTX-1:0]            intx_en,
    output logic                         err_stat_wr,
    output logic                         err_set_wr,
    output logic                         err_clr_wr,
    output logic [N_INTX-1:0]            intx_set_wr,
    output logic [N_INTX-1:0]            intx_clr_wr,
    output logic [N_INTX-1:0]            eoi_vec,
    output logic [eic_pkg::DATA_W-1:0]   rdata
);
    import eic_pkg::*;

    logic              hit_err_stat, hit_err_set, hit_err_clr, hit_eoi;
    logic [N_INTX-1:0] hit_stat, hit_set, hit_clr;

    // Fixed-offset hits.
    always_comb begin
        hit_err_stat = (reg_addr == AW'(ERR_STAT_OFS));
        hit_err_set  = (reg_addr == AW'(ERR_SET_OFS));
        hit_err_clr  = (reg_addr == AW'(ERR_CLR_OFS));
        hit_eoi      = (reg_addr == AW'(EOI_OFS));
    end

    // Per-line hits and end-of-interrupt decode, one group per legacy line.
    for (genvar i = 0; i < N_INTX; i++) begin : g_line
        assign hit_stat[i]    = (reg_addr == AW'(INTX_STAT_OFS + INTX_STRIDE * i));
        assign hit_set[i]     = (reg_addr == AW'(INTX_SET_OFS  + INTX_STRIDE * i));
        assign hit_clr[i]     = (reg_addr == AW'(INTX_CLR_OFS  + INTX_STRIDE * i));
        assign intx_set_wr[i] = reg_wr && hit_set[i];
        assign intx_clr_wr[i] = reg_wr && hit_clr[i];
        assign eoi_vec[i]     = reg_wr && hit_eoi && (reg_wdata == DATA_W'(i));
    end

    // Write strobes for the error bank.
    always_comb begin
        err_stat_wr = reg_wr && hit_err_stat;
        err_set_wr  = reg_wr && hit_err_set;
        err_clr_wr  = reg_wr && hit_err_clr;
    end

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        if (hit_err_stat)
            rdata[ERR_W-1:0] = err_stat;
        if (hit_err_set || hit_err_clr)
            rdata[ERR_W-1:0] = err_en;
        for (int i = 0; i < N_INTX; i++) begin
            if (hit_stat[i])
                rdata[0] = intx_stat[i];
            if (hit_set[i] || hit_clr[i])
                rdata[0] = intx_en[i];
        end
    end

    // R9: a write reaches at most one register target.
    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_stat_wr, err_set_wr, err_clr_wr, intx_set_wr, intx_clr_wr,
                  reg_wr && hit_eoi}))
        else $error("write decoded to more than one target");
endmodule

// File: rtl/eic_err_bank.sv
`timescale 1ns/1ps
// Error status bank: sticky event capture with write-one-to-clear, an enable
// mask changed through set and clear writes, and the summary and fatal
// outputs. Assumes the event strobes are synchronous to clk.
module eic_err_bank #(
    parameter int                         W     = 6,
    parameter logic [W-1:0]               FMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] event_i,
    input  logic [W-1:0] wdata_i,
    input  logic         stat_wr_i,
    input  logic         set_wr_i,
    input  logic         clr_wr_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         irq_o,
    output logic         fatal_o
);
    logic [W-1:0] stat_q, en_q, clr_mask;

    // Bits named in a status write are cleared; an event in the same cycle wins.
    always_comb clr_mask = stat_wr_i ? wdata_i : '0;

    // Sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | event_i;
    end

    // Enable mask, changed by set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (set_wr_i) en_q <= en_q | wdata_i;
        else if (clr_wr_i) en_q <= en_q & ~wdata_i;
    end

    // Summary and fatal-class outputs.
    always_comb begin
        irq_o   = |(stat_q & en_q);
        fatal_o = |(stat_q & en_q & FMASK);
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;

    // R2: a status bit never falls unless a status write named it.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q) & ~$past(clr_mask)) ==
                  ($past(stat_q) & ~$past(clr_mask))))
        else $error("status bit lost without clear");

    // R2: every asserted event is visible in status one edge later.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((stat_q & $past(event_i)) == $past(event_i)))
        else $error("event not captured");
endmodule

// File: rtl/eic_intx_line.sv
`timescale 1ns/1ps
// One legacy interrupt line: level tracking status, enable bit, and an arm
// flag that makes the host output a single-cycle pulse per end-of-interrupt.
// Assumes level_i is synchronous to clk.
module eic_intx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic set_wr_i,
    input  logic clr_wr_i,
    input  logic wbit_i,
    input  logic eoi_i,
    output logic stat_o,
    output logic en_o,
    output logic irq_o
);
    logic stat_q, en_q, armed_q, fire;

    // Status follows the input level one edge late.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= level_i;
    end

    // Enable bit via set and clear writes of bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= 1'b0;
        else if (set_wr_i && wbit_i)  en_q <= 1'b1;
        else if (clr_wr_i && wbit_i)  en_q <= 1'b0;
    end

    // Host pulse condition.
    always_comb fire = stat_q && en_q && armed_q;

    // Arm flag: dropped by a pulse, restored by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b1;
        else if (eoi_i) armed_q <= 1'b1;
        else if (fire)  armed_q <= 1'b0;
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = fire;

    // R7: a pulse lasts one cycle unless an end-of-interrupt arrives with it.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !eoi_i) |=> !irq_o)
        else $error("legacy pulse longer than one cycle");

    // R8: a disarmed line stays quiet until re-armed.
    a_r8_quiet_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !eoi_i) |=> !irq_o)
        else $error("legacy line fired while disarmed");
endmodule

// File: rtl/eic_top.sv
`timescale 1ns/1ps
// Error and legacy interrupt status controller, top level.
// Connects the decoder, the error bank and one line module per legacy input.
// Assumes N_INTX <= 4 (legacy groups must end below the error status word).
module eic_top #(
    parameter int AW     = 12,
    parameter int N_INTX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [AW-1:0]              reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic [eic_pkg::ERR_W-1:0]  err_event,
    input  logic [N_INTX-1:0]          intx_level,
    output logic                       err_irq,
    output logic                       err_fatal,
    output logic [N_INTX-1:0]          intx_irq
);
    import eic_pkg::*;

    logic              err_stat_wr, err_set_wr, err_clr_wr;
    logic [ERR_W-1:0]  err_stat, err_en;
    logic [N_INTX-1:0] intx_set_wr, intx_clr_wr, eoi_vec, intx_stat, intx_en;

    // Register decode and read path.
    eic_decode #(.AW(AW), .N_INTX(N_INTX)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .err_stat(err_stat), .err_en(err_en),
        .intx_stat(intx_stat), .intx_en(intx_en),
        .err_stat_wr(err_stat_wr), .err_set_wr(err_set_wr), .err_clr_wr(err_clr_wr),
        .intx_set_wr(intx_set_wr), .intx_clr_wr(intx_clr_wr),
        .eoi_vec(eoi_vec), .rdata(reg_rdata)
    );

    // Error status bank.
    eic_err_bank #(.W(ERR_W), .FMASK(FATAL_MASK)) u_err (
        .clk(clk), .rst_n(rst_n),
        .event_i(err_event), .wdata_i(reg_wdata[ERR_W-1:0]),
        .stat_wr_i(err_stat_wr), .set_wr_i(err_set_wr), .clr_wr_i(err_clr_wr),
        .stat_o(err_stat), .en_o(err_en),
        .irq_o(err_irq), .fatal_o(err_fatal)
    );

    // One legacy line per input.
    for (genvar i = 0; i < N_INTX; i++) begin : g_intx
        eic_intx_line u_line (
            .clk(clk), .rst_n(rst_n),
            .level_i(intx_level[i]),
            .set_wr_i(intx_set_wr[i]), .clr_wr_i(intx_clr_wr[i]),
            .wbit_i(reg_wdata[0]), .eoi_i(eoi_vec[i]),
            .stat_o(intx_stat[i]), .en_o(intx_en[i]), .irq_o(intx_irq[i])
        );
    end

    // R4: the fatal output implies the summary output.
    a_r4_fatal_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_fatal |-> err_irq)
        else $error("fatal without summary interrupt");

    // R1: outputs are quiet in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!err_irq && !err_fatal && intx_irq == '0))
        else $error("outputs active after reset");
endmodule

// File: tb/eic_top_bench.sv
`timescale 1ns/1ps
module eic_top_bench;
    localparam int AW = 12;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [5:0]    err_event = '0;
    logic [NI-1:0] intx_level = '0;
    logic          err_irq, err_fatal;
    logic [NI-1:0] intx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    eic_top #(.AW(AW), .N_INTX(NI)) u_eic_top (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_event(err_event), .intx_level(intx_level),
        .err_irq(err_irq), .err_fatal(err_fatal), .intx_irq(intx_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        #0.5;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [5:0]  m, q;
        int          base;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 err_irq", {31'b0, err_irq}, 0);
        check("R1 err_fatal", {31'b0, err_fatal}, 0);
        check("R1 intx_irq", {28'b0, intx_irq}, 0);
        rd(12'h1C4, d); check("R1 err status", d, 0);
        rd(12'h1C8, d); check("R1 err enable", d, 0);
        for (int i = 0; i < NI; i++) begin
            rd(AW'(12'h188 + 16 * i), d); check("R1 intx enable", d, 0);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2/R3/R4: sweep all 64 event patterns against varied enable masks
        for (int p = 0; p < 64; p++) begin
            m = 6'((p * 29 + 7) & 63);
            q = 6'(p) ^ 6'h2A;
            wr(12'h1C4, 32'h3F);
            wr(12'h1CC, 32'h3F);
            wr(12'h1C8, {26'b0, m});
            @(negedge clk); err_event = 6'(p);
            @(negedge clk); err_event = '0;
            #0.5;
            rd(12'h1C4, d); check("R2 capture", d, {26'b0, 6'(p)});
            rd(12'h1CC, d); check("R3 enable readback", d, {26'b0, m});
            check("R4 err_irq", {31'b0, err_irq}, {31'b0, |(6'(p) & m)});
            check("R4 err_fatal", {31'b0, err_fatal}, {31'b0, |(6'(p) & m & 6'h12)});
            wr(12'h1C4, {26'b0, q});
            rd(12'h1C4, d); check("R2 partial clear", d, {26'b0, 6'(p) & ~q});
            check("R4 err_irq after clear", {31'b0, err_irq}, {31'b0, |(6'(p) & ~q & m)});
        end

        // R2: event beats clear in the same cycle
        wr(12'h1C4, 32'h3F);
        @(negedge clk);
        err_event = 6'h01; reg_wr = 1'b1; reg_addr = 12'h1C4; reg_wdata = 32'h3F;
        @(negedge clk);
        err_event = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(12'h1C4, d); check("R2 set wins over clear", d, 32'h01);
        // R2: writing zero leaves status
        wr(12'h1C4, 32'h0);
        rd(12'h1C4, d); check("R2 zero write keeps", d, 32'h01);
        // R3: zero writes to set/clear change nothing
        wr(12'h1CC, 32'h3F); wr(12'h1C8, 32'h15);
        wr(12'h1C8, 32'h0); wr(12'h1CC, 32'h0);
        rd(12'h1C8, d); check("R3 zero writes keep mask", d, 32'h15);
        // R9: unmapped writes change nothing, unmapped reads give zero
        wr(12'h1D0, 32'h3F); wr(12'h1C0, 32'h3F); wr(12'h180, 32'h3F);
        rd(12'h1C8, d); check("R9 unmapped write ignored", d, 32'h15);
        rd(12'h1C4, d); check("R9 status not aliased", d, 32'h01);
        rd(12'h1C0, d); check("R9 unmapped read 0x1C0", d, 0);
        rd(12'h1D0, d); check("R9 unmapped read 0x1D0", d, 0);
        rd(12'h050, d); check("R9 eoi reads zero", d, 0);
        wr(12'h1C4, 32'h3F); wr(12'h1CC, 32'h3F);

        // R5..R8: each legacy line in turn
        for (int i = 0; i < NI; i++) begin
            base = 'h184 + 16 * i;
            @(negedge clk); intx_level[i] = 1'b1;
            @(negedge clk); #0.5;
            rd(AW'(base), d); check("R5 status follows level", d, 1);
            check("R6 disabled no pulse", {28'b0, intx_irq}, 0);
            wr(AW'(base), 32'h0);
            rd(AW'(base), d); check("R5 status write ignored", d, 1);
            wr(AW'(base + 4), 32'h1);
            check("R7 pulse on enable", {28'b0, intx_irq}, 32'(1 << i));
            @(negedge clk); #0.5;
            check("R7 pulse one cycle", {28'b0, intx_irq}, 0);
            repeat (3) @(negedge clk);
            #0.5;
            check("R7 held off while level high", {28'b0, intx_irq}, 0);
            rd(AW'(base + 8), d); check("R6 enable read via clear offset", d, 1);
            wr(12'h050, 32'(i + 4));
            check("R8 out-of-range eoi ignored", {28'b0, intx_irq}, 0);
            wr(12'h050, 32'((i + 1) % NI));
            check("R8 other-line eoi ignored", {28'b0, intx_irq}, 0);
            wr(12'h050, 32'(i));
            check("R8 eoi re-fires", {28'b0, intx_irq}, 32'(1 << i));
            @(negedge clk); #0.5;
            check("R8 refire one cycle", {28'b0, intx_irq}, 0);
            intx_level[i] = 1'b0;
            @(negedge clk); #0.5;
            rd(AW'(base), d); check("R5 status follows low", d, 0);
            wr(12'h050, 32'(i));
            check("R8 eoi with level low", {28'b0, intx_irq}, 0);
            wr(AW'(base + 8), 32'h1);
            rd(AW'(base + 4), d); check("R6 enable cleared", d, 0);
            intx_level[i] = 1'b1;
            repeat (2) @(negedge clk);
            #0.5;
            check("R6 disabled line quiet", {28'b0, intx_irq}, 0);
            intx_level[i] = 1'b0;
            @(negedge clk);
        end
        // R9: error offsets do not reach legacy lines
        wr(12'h1C8, 32'h3F);
        intx_level = '1;
        repeat (2) @(negedge clk);
        #0.5;
        check("R9 no legacy alias at 0x1C8", {28'b0, intx_irq}, 0);
        intx_level = '0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule